// File: doc/BRIEF.md
# Half-Rate Speculative First-Tap Decision Feedback Slicer

This block resolves binary symbols from equalized receiver samples and cancels the first post-cursor of inter-symbol interference. It does not subtract a feedback term from each sample before slicing. Instead it slices every sample against two thresholds at once, +w1 and −w1. The symbol decided just before then picks one of the two results. The subtraction that would otherwise have to settle within one unit interval leaves the timing loop. What remains in the loop is a chain of 2:1 selectors.

Samples arrive as a group of `LANES` per clock, two by default, which gives a half-rate front end. Lane 0 carries the earliest symbol of the group. Lane 0 selects with the last decision of the previous accepted group. Each later lane selects with the decision of the lane just before it in the same group. The feedback coefficient w1 is a signed programmable input. Decisions are registered and appear one clock after a group is accepted.

Top module: `spec_dfe_hr`

## Requirements
- R1: While `rst_n` is low, `dec_o` is all zeros and `dec_valid_o` is 0. `dec_valid_o` is 1 exactly in the clock after a cycle with `samp_valid_i` high. The new decisions appear on `dec_o` in that same clock.
- R2: Decision encoding is 1 for +1 and 0 for −1. When the selecting previous decision is +1, a lane decides +1 exactly when its sample y satisfies y − w1 ≥ 0.
- R3: When the selecting previous decision is −1, a lane decides +1 exactly when y + w1 ≥ 0.
- R4: A comparison result of exactly zero decides +1. This covers both y = w1 under a +1 history and y = −w1 under a −1 history.
- R5: Lane i occupies `samp_i[i*SAMPLE_W +: SAMPLE_W]` and `dec_o[i]`. Lane 0 selects with `dec_o[LANES-1]` of the previous accepted group. Lane i > 0 selects with lane i−1 of the same group.
- R6: The first group accepted after reset is sliced as though the previous decision were +1.
- R7: Cycles with `samp_valid_i` low leave `dec_o` unchanged. They also leave the decision history unchanged, whatever the sample and w1 inputs hold.
- R8: The comparisons do not overflow at the extremes of the two's complement ranges of the sample and of w1 (for example y = −128 with w1 = −128, or y = 127 with w1 = −128).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| samp_valid_i | input | 1 | Sample group present this cycle |
| samp_i | input | LANES*SAMPLE_W | Signed samples, lane 0 in the low bits, earliest in time |
| w1_i | input | TAP_W | Signed first-tap coefficient |
| dec_o | output | LANES | Registered decisions, 1 = +1, 0 = −1 |
| dec_valid_o | output | 1 | `dec_o` was updated in this clock |

## Verification
The hardest case to bring about from the ports is a sample that lies between −w1 and +w1. Only there do the two candidates differ, and only there does the selection by the previous bit decide the outcome. This matters most at a group boundary, where lane 0 depends on the previous group. The random stimulus draws w1 and samples from the same narrow range so that this window is hit often. Idle gaps are mixed in so that the history has to survive across them. Directed cases place samples exactly on ±w1 and at the range extremes. A mid-run reset is followed by a group whose lane 0 sits inside the window.

// File: rtl/spec_dfe_pkg.sv
package spec_dfe_pkg;

   typedef enum logic {
      DEC_NEG = 1'b0,
      DEC_POS = 1'b1
   } dec_e;

   function automatic int cmp_width(input int samp_w, input int tap_w);
      int m;
      m = (samp_w > tap_w) ? samp_w : tap_w;
      return m + 2;
   endfunction

endpackage

// File: rtl/spec_dfe_slicer_pair.sv
module spec_dfe_slicer_pair #(
   parameter int SAMPLE_W = 8,
   parameter int TAP_W    = 8
) (
   input  logic signed [SAMPLE_W-1:0] samp_i,
   input  logic signed [TAP_W-1:0]    w1_i,
   output logic                       dec_if_pos_o,
   output logic                       dec_if_neg_o
);
   import spec_dfe_pkg::*;

   localparam int CW = cmp_width(SAMPLE_W, TAP_W);

   logic signed [CW-1:0] y_ext;
   logic signed [CW-1:0] w_ext;
   logic signed [CW-1:0] w_neg;

   always_comb begin
      y_ext = CW'(samp_i);
      w_ext = CW'(w1_i);
      w_neg = -w_ext;
   end

   // history +1: slice y - w1 ; zero counts as +1
   assign dec_if_pos_o = (y_ext >= w_ext) ? DEC_POS : DEC_NEG;
   // history -1: slice y + w1 ; zero counts as +1
   assign dec_if_neg_o = (y_ext >= w_neg) ? DEC_POS : DEC_NEG;

endmodule

// File: rtl/spec_dfe_lane_chain.sv
module spec_dfe_lane_chain #(
   parameter int LANES = 2
) (
   input  logic             prev_i,
   input  logic [LANES-1:0] cand_pos_i,
   input  logic [LANES-1:0] cand_neg_i,
   output logic [LANES-1:0] dec_o
);

   always_comb begin
      logic sel;
      sel = prev_i;
      for (int i = 0; i < LANES; i++) begin
         dec_o[i] = sel ? cand_pos_i[i] : cand_neg_i[i];
         sel      = dec_o[i];
      end
   end

endmodule

// File: rtl/spec_dfe_dec_reg.sv
module spec_dfe_dec_reg #(
   parameter int LANES     = 2,
   parameter bit PREV_INIT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [LANES-1:0] dec_i,
   output logic [LANES-1:0] dec_o,
   output logic             valid_o,
   output logic             prev_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_o   <= '0;
         valid_o <= 1'b0;
         prev_o  <= PREV_INIT;
      end else begin
         valid_o <= load_i;
         if (load_i) begin
            dec_o  <= dec_i;
            prev_o <= dec_i[LANES-1];
         end
      end
   end

   a_r1_valid_follows : assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> valid_o);
   a_r1_valid_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> !valid_o);
   a_r7_hold_idle : assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> ($stable(dec_o) && $stable(prev_o)));

endmodule

// File: rtl/spec_dfe_hr.sv
module spec_dfe_hr #(
   parameter int SAMPLE_W  = 8,
   parameter int TAP_W     = 8,
   parameter int LANES     = 2,
   parameter bit PREV_INIT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      samp_valid_i,
   input  logic [LANES*SAMPLE_W-1:0] samp_i,
   input  logic signed [TAP_W-1:0]   w1_i,
   output logic [LANES-1:0]          dec_o,
   output logic                      dec_valid_o
);

   generate
      if (SAMPLE_W < 2) begin : g_bad_sw
         $error("SAMPLE_W must be at least 2");
      end
      if (TAP_W < 2) begin : g_bad_tw
         $error("TAP_W must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
   endgenerate

   logic [LANES-1:0] cand_pos;
   logic [LANES-1:0] cand_neg;
   logic [LANES-1:0] dec_next;
   logic             prev_dec;

   genvar gi;
   generate
      for (gi = 0; gi < LANES; gi++) begin : g_lane
         spec_dfe_slicer_pair #(
            .SAMPLE_W (SAMPLE_W),
            .TAP_W    (TAP_W)
         ) u_slice (
            .samp_i       (samp_i[gi*SAMPLE_W +: SAMPLE_W]),
            .w1_i         (w1_i),
            .dec_if_pos_o (cand_pos[gi]),
            .dec_if_neg_o (cand_neg[gi])
         );

         // R2/R3: when both candidates agree, the history cannot matter
         a_r2_agree : assert property (@(posedge clk) disable iff (!rst_n)
            (samp_valid_i && (cand_pos[gi] == cand_neg[gi]))
               |=> (dec_o[gi] == $past(cand_pos[gi])));

         // R3: with w1 >= 0 the -w1 threshold is never above +w1
         a_r3_order : assert property (@(posedge clk) disable iff (!rst_n)
            (samp_valid_i && (w1_i >= 0) && cand_pos[gi]) |-> cand_neg[gi]);
      end
   endgenerate

   spec_dfe_lane_chain #(
      .LANES (LANES)
   ) u_chain (
      .prev_i     (prev_dec),
      .cand_pos_i (cand_pos),
      .cand_neg_i (cand_neg),
      .dec_o      (dec_next)
   );

   spec_dfe_dec_reg #(
      .LANES     (LANES),
      .PREV_INIT (PREV_INIT)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (samp_valid_i),
      .dec_i   (dec_next),
      .dec_o   (dec_o),
      .valid_o (dec_valid_o),
      .prev_o  (prev_dec)
   );

   // R5: lane 0 of a group follows the history left by the last lane
   a_r5_history : assert property (@(posedge clk) disable iff (!rst_n)
      samp_valid_i |=> (prev_dec == dec_o[LANES-1]));

endmodule

// File: tb/spec_dfe_hr_tb.sv
module spec_dfe_hr_tb;

   localparam int SW = 8;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          vld = 1'b0;
   logic [2*SW-1:0] samp = '0;
   logic signed [TW-1:0] w1 = '0;
   logic [1:0]    dec;
   logic          dv;

   int n_cmp = 0;
   int n_bad = 0;
   bit ref_prev = 1'b1;
   bit [1:0] last_dec = 2'b00;
   bit done = 1'b0;

   always #10 clk = ~clk;

   spec_dfe_hr #(.SAMPLE_W(SW), .TAP_W(TW), .LANES(2)) u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .samp_valid_i (vld),
      .samp_i       (samp),
      .w1_i         (w1),
      .dec_o        (dec),
      .dec_valid_o  (dv)
   );

   function automatic bit slice(int y, int w, bit prev);
      return prev ? (y - w >= 0) : (y + w >= 0);
   endfunction

   task automatic chk(string tag, string what, int got, int exp);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      vld   = 1'b0;
      repeat (2) @(negedge clk);
      chk("R1", "dec_o in reset", int'(dec), 0);
      chk("R1", "dec_valid_o in reset", int'(dv), 0);
      rst_n    = 1'b1;
      ref_prev = 1'b1;
      last_dec = 2'b00;
   endtask

   task automatic send(int y0, int y1, int w, string tag);
      bit e0, e1;
      samp = {y1[SW-1:0], y0[SW-1:0]};
      w1   = w[TW-1:0];
      vld  = 1'b1;
      e0 = slice(y0, w, ref_prev);
      e1 = slice(y1, w, e0);
      ref_prev = e1;
      @(negedge clk);
      chk("R1", "dec_valid_o after group", int'(dv), 1);
      chk(tag, "lane0", int'(dec[0]), int'(e0));
      chk(tag, "lane1", int'(dec[1]), int'(e1));
      last_dec = {e1, e0};
   endtask

   task automatic idle();
      vld  = 1'b0;
      samp = 16'($urandom);
      w1   = TW'($urandom);
      @(negedge clk);
      chk("R1", "dec_valid_o idle", int'(dv), 0);
      chk("R7", "dec_o held idle", int'(dec), int'(last_dec));
   endtask

   function automatic int rnd_range(int lo, int hi);
      return lo + int'($urandom % (hi - lo + 1));
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // R6: first group after reset, lane 0 inside the window: history +1 gives 0
      send(0, 0, 10, "R6");
      // R4: exact zero under +1 history (prev now 1 from lane1)
      send(10, -5, 10, "R4");
      // lane0: 10-10=0 -> 1 ; lane1: -5-10 <0 -> 0
      // R4: exact zero under -1 history
      send(-10, 3, 10, "R4");
      // R2 and R3 distinct windows
      send(5, 5, 20, "R3");
      send(25, -15, 20, "R2");
      // R8 extremes
      send(-128, 127, -128, "R8");
      send(127, -128, -128, "R8");
      send(-128, -128, 127, "R8");
      send(127, 127, 127, "R8");
      // R7: gap must keep history
      send(0, 40, 30, "R5");
      idle();
      idle();
      send(0, 0, 30, "R7");
      send(-1, 1, 30, "R5");

      // R6: reset mid-run, then a window sample
      send(50, 50, 10, "R5");
      do_reset();
      @(negedge clk);
      send(0, 0, 10, "R6");

      // random, sample and w1 in the same narrow range so windows are hit
      for (int k = 0; k < 2500; k++) begin
         int w, a, b;
         if (($urandom % 4) == 0) idle();
         if (($urandom % 8) == 0) begin
            w = rnd_range(-128, 127);
            a = rnd_range(-128, 127);
            b = rnd_range(-128, 127);
         end else begin
            w = rnd_range(-40, 40);
            a = rnd_range(-45, 45);
            b = rnd_range(-45, 45);
         end
         send(a, b, w, "R5");
      end
      idle();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_bad++;
         n_cmp++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule